// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block is a 32-pin general-purpose I/O controller with a small memory-mapped register port. Software sets each pin's drive level and direction with single writes that carry their own per-bit enables, so a bit can be changed without reading the register first and without locking against other writers. Each 32-bit write holds a 16-bit value in its lower half and a 16-bit enable mask in its upper half. For that reason the 32 pins are split into a low half-register and a high half-register, for both the level and the direction function.

The pad side gives a drive value and an output-enable for each pin, and takes the pin levels back in. The levels are resynchronised and can be read as one 32-bit word. A fixed identifier word lets software detect this register layout. Reads are combinational from the address within the same cycle. Writes take effect at the next rising clock edge.

Top module: `gpio_mw_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every stored level and direction bit is 0. This makes `pad_oe` and `pad_out` all zero.
- R2: A write at byte offset 0x00 updates level bits for pins 0..15. Data bit n (n = 0..15) is taken only where write bit n+16 is 1, and bits whose enable is 0 keep their value. `pad_out[15:0]` shows the result after the clock edge.
- R3: A write at offset 0x04 updates level bits for pins 16..31 under the same rule. Write bit n+16 guards write bit n, which lands on pin n+16.
- R4: Writes at offset 0x08 (pins 0..15) and 0x0C (pins 16..31) update direction bits with the same masked rule. `pad_oe[n]` equals direction bit n, where 1 means output and 0 means input.
- R5: A read at 0x00, 0x04, 0x08 or 0x0C returns the 16 stored bits of that half-register in [15:0] and zeros in [31:16]. The enables of earlier writes are not kept.
- R6: A read at 0x70 returns the pin levels with bit n holding pin n. Each level reaches the register two rising edges after it is applied to `pad_in`.
- R7: A read at 0x78 returns the constant 0x0101157C.
- R8: Writes at 0x70, 0x78 or any unmapped offset change neither `pad_out` nor `pad_oe`. Reads at unmapped offsets return 0. An offset with nonzero bits [1:0] counts as unmapped.
- R9: A read at an address that is written in the same cycle returns the value stored before that write. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write word: [31:16] enables, [15:0] values |
| bus_rdata | output | 32 | Read word for `bus_addr`, combinational |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Drive value per pin |
| pad_oe | output | 32 | Output enable per pin |

## Verification
A register read and a write to the same register can fall in the same cycle, and they interact through the combinational read path. The bench places a write and a read of one half-register in a single cycle. It checks that the returned word still holds the old bits, and that the new masked value appears one edge later. A second overlap is a pin level change at the same time as a port-level read. It is judged by sampling the 0x70 word after one edge (old value) and after two edges (new value). Random masked writes over all offsets, including read-only and unmapped ones, are compared against a bench model of the four half-registers.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

    localparam int PIN_COUNT  = 32;
    localparam int HALF_W     = 16;
    localparam int ADDR_W     = 8;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] OFS_LVL_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LVL_HI = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIR_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PINS   = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h78;

    localparam logic [WORD_W-1:0] IDENT_WORD = 32'h0101_157C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LVL_LO,
        SEL_LVL_HI,
        SEL_DIR_LO,
        SEL_DIR_HI,
        SEL_PINS,
        SEL_IDENT
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] val;
    } mwrite_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_LVL_LO: s = SEL_LVL_LO;
            OFS_LVL_HI: s = SEL_LVL_HI;
            OFS_DIR_LO: s = SEL_DIR_LO;
            OFS_DIR_HI: s = SEL_DIR_HI;
            OFS_PINS:   s = SEL_PINS;
            OFS_IDENT:  s = SEL_IDENT;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] merge_masked(input logic [HALF_W-1:0] old,
                                                       input mwrite_t w);
        return (old & ~w.en) | (w.val & w.en);
    endfunction

endpackage

// File: rtl/gpio_mw_halfreg.sv
module gpio_mw_halfreg
    import gpio_mw_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [2*W-1:0] wword,
    output logic [W-1:0]   q
);
    logic [W-1:0] en_bits;
    logic [W-1:0] val_bits;
    logic [W-1:0] nxt;

    assign en_bits  = wword[2*W-1:W];
    assign val_bits = wword[W-1:0];

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            assign nxt[b] = en_bits[b] ? val_bits[b] : q[b];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
    import gpio_mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    localparam int HALVES = PIN_COUNT / HALF_W;

    reg_sel_e          sel;
    logic [HALVES-1:0] lvl_we;
    logic [HALVES-1:0] dir_we;
    logic [HALF_W-1:0] lvl_q [HALVES];
    logic [HALF_W-1:0] dir_q [HALVES];
    logic [PIN_COUNT-1:0] pins_sync;

    assign sel = decode_addr(bus_addr);

    always_comb begin
        lvl_we = '0;
        dir_we = '0;
        if (bus_wr) begin
            case (sel)
                SEL_LVL_LO: lvl_we[0] = 1'b1;
                SEL_LVL_HI: lvl_we[HALVES-1] = 1'b1;
                SEL_DIR_LO: dir_we[0] = 1'b1;
                SEL_DIR_HI: dir_we[HALVES-1] = 1'b1;
                default: ;
            endcase
        end
    end

    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            gpio_mw_halfreg #(.W(HALF_W)) u_lvl (
                .clk   (clk),
                .rst   (rst),
                .we    (lvl_we[h]),
                .wword (bus_wdata),
                .q     (lvl_q[h])
            );
            gpio_mw_halfreg #(.W(HALF_W)) u_dir (
                .clk   (clk),
                .rst   (rst),
                .we    (dir_we[h]),
                .wword (bus_wdata),
                .q     (dir_q[h])
            );
            assign pad_out[h*HALF_W +: HALF_W] = lvl_q[h];
            assign pad_oe [h*HALF_W +: HALF_W] = dir_q[h];
        end
    endgenerate

    gpio_mw_sync #(.W(PIN_COUNT), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LVL_LO: bus_rdata[HALF_W-1:0] = lvl_q[0];
            SEL_LVL_HI: bus_rdata[HALF_W-1:0] = lvl_q[HALVES-1];
            SEL_DIR_LO: bus_rdata[HALF_W-1:0] = dir_q[0];
            SEL_DIR_HI: bus_rdata[HALF_W-1:0] = dir_q[HALVES-1];
            SEL_PINS:   bus_rdata = pins_sync;
            SEL_IDENT:  bus_rdata = IDENT_WORD;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mw_chk.sv
module gpio_mw_chk
    import gpio_mw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [PIN_COUNT-1:0] pad_in,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe
);
    logic       rst_q = 1'b0;
    logic [1:0] since_rst = 2'd0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst && rst_q) begin
            reset_clear_chk: assert (pad_oe == '0 && pad_out == '0);
        end
    end

    // R2
    lvl_lo_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LVL_LO) |=>
        pad_out[15:0] == (($past(pad_out[15:0]) & ~$past(bus_wdata[31:16])) |
                          ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R3
    lvl_hi_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LVL_HI) |=>
        pad_out[31:16] == (($past(pad_out[31:16]) & ~$past(bus_wdata[31:16])) |
                           ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == OFS_DIR_LO || bus_addr == OFS_DIR_HI)) |=> $stable(pad_oe));

    // R5
    readback_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_LVL_LO || bus_addr == OFS_LVL_HI ||
         bus_addr == OFS_DIR_LO || bus_addr == OFS_DIR_HI) |-> bus_rdata[31:16] == 16'h0);

    // R6
    pin_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && bus_addr == OFS_PINS) |-> bus_rdata == $past(pad_in, 2));

    // R7
    ident_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_IDENT) |-> bus_rdata == IDENT_WORD);

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != OFS_LVL_LO && bus_addr != OFS_LVL_HI &&
         bus_addr != OFS_DIR_LO && bus_addr != OFS_DIR_HI) |=>
        ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_mw_bank gpio_mw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mw_bank_test.sv
`timescale 1ns/1ps
module gpio_mw_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_lvl [2];
    logic [15:0] m_dir [2];
    logic [31:0] pins_now;

    always #2.5 clk = ~clk;

    gpio_mw_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mrg(input logic [15:0] old, input logic [31:0] w);
        return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_lvl[0]};
            8'h04: return {16'h0, m_lvl[1]};
            8'h08: return {16'h0, m_dir[0]};
            8'h0C: return {16'h0, m_dir[1]};
            8'h70: return pins_now;
            8'h78: return 32'h0101157C;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] w);
        case (a)
            8'h00: m_lvl[0] = mrg(m_lvl[0], w);
            8'h04: m_lvl[1] = mrg(m_lvl[1], w);
            8'h08: m_dir[0] = mrg(m_dir[0], w);
            8'h0C: m_dir[1] = mrg(m_dir[1], w);
            default: ;
        endcase
    endtask

    // drives at negedge, one posedge, returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] w);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, w);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        bus_addr = a; #0.5;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic pads_check(input string req);
        check(req, pad_out, {m_lvl[1], m_lvl[0]});
        check(req, pad_oe,  {m_dir[1], m_dir[0]});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] addrs [10];
        void'($urandom(32'd20240611));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h70, 8'h78, 8'h10, 8'h02, 8'h7C, 8'hFC};
        m_lvl = '{16'h0, 16'h0};
        m_dir = '{16'h0, 16'h0};
        pins_now = 32'h0;
        repeat (3) @(negedge clk);
        // R1 during reset
        pads_check("R1");
        rst = 1'b0;
        @(negedge clk);
        pads_check("R1");
        rd_check("R1", 8'h00);
        rd_check("R1", 8'h0C);

        // R2 low level, partial enables
        wr(8'h00, 32'h00FF_A5A5); pads_check("R2");
        wr(8'h00, 32'hF000_0000); pads_check("R2");
        wr(8'h00, 32'h0000_FFFF); pads_check("R2");   // no enables
        // R3 high level
        wr(8'h04, 32'hFFFF_1234); pads_check("R3");
        wr(8'h04, 32'h8001_0000); pads_check("R3");
        // R4 direction both halves
        wr(8'h08, 32'h0F0F_FFFF); pads_check("R4");
        wr(8'h0C, 32'hFFFF_C003); pads_check("R4");
        // R5 readback with upper zeros
        rd_check("R5", 8'h00); rd_check("R5", 8'h04);
        rd_check("R5", 8'h08); rd_check("R5", 8'h0C);
        // R7 identifier
        rd_check("R7", 8'h78);
        // R8 ignored writes and unmapped reads
        wr(8'h70, 32'hFFFF_FFFF); pads_check("R8");
        wr(8'h78, 32'hFFFF_0000); pads_check("R8");
        wr(8'h01, 32'hFFFF_FFFF); pads_check("R8");
        wr(8'h40, 32'hFFFF_FFFF); pads_check("R8");
        rd_check("R8", 8'h40); rd_check("R8", 8'h09);
        rd_check("R7", 8'h78);

        // R9 read and write of one register in the same cycle
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'hFFFF_5A5A;
        #0.5 check("R9", bus_rdata, {16'h0, m_dir[0]});
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        model_write(8'h08, 32'hFFFF_5A5A);
        #0.5 check("R9", bus_rdata, {16'h0, m_dir[0]});

        // R6 pin level latency
        bus_addr = 8'h70;
        pad_in = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        check("R6", bus_rdata, 32'h0);
        @(posedge clk); @(negedge clk);
        pins_now = 32'hDEAD_BEEF;
        rd_check("R6", 8'h70);
        pad_in = 32'h1357_9BDF;
        @(posedge clk); @(negedge clk);
        check("R6", bus_rdata, 32'hDEAD_BEEF);
        @(posedge clk); @(negedge clk);
        pins_now = 32'h1357_9BDF;
        rd_check("R6", 8'h70);

        // random masked writes across all offsets
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] w;
            a = addrs[$urandom_range(0, 9)];
            w = $urandom;
            if (($urandom & 3) == 0) w[31:16] = 16'h0;
            wr(a, w);
            pads_check(a inside {8'h00, 8'h04} ? "R2/R3" :
                       a inside {8'h08, 8'h0C} ? "R4" : "R8");
            rd_check("R5", addrs[$urandom_range(0, 9)]);
        end

        // R1 reset again clears everything
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_lvl = '{16'h0, 16'h0};
        m_dir = '{16'h0, 16'h0};
        pads_check("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule